// File: doc/BRIEF.md
# I2C Master Command and Status Unit

This unit is the command engine of an I2C bus master. Software drives it through a small register port. It can ask for a start condition, a repeated start, a stop condition or a single transmitted byte. Each request becomes a fixed sequence of bus phases on open-drain SCL and SDA. Every phase lasts one tick of a programmable clock divider. The unit keeps a set of sticky status flags and raises one interrupt line through per-flag enables.

Each operation is a separate command. The unit accepts it, shows command-busy while it runs, and signals completion by setting a shared session-done flag. Software clears that flag by writing 1 to it. After a byte, the acknowledge bit the slave returned is captured into both the status register and the control register. Between commands the bus lines hold their last state, so a start, a byte and a stop can be chained as separate steps. Register addresses: 0 control, 1 data, 2 status, 3 interrupt enable, 4 divider. SCL and SDA are reported as "drive low" outputs (1 = pull the line low, 0 = release it).

Top module: `i2cm_cmd_unit`

## Requirements
- R1: After reset both lines are released, the control, data, status and interrupt enable registers read 0, the divider register reads DIV_RESET (4), and irq is low.
- R2: Control register fields are enable (bit 0), command (bits 2:1, where 1 is start/restart, 2 is stop, and 0 or 3 is no action) and bit 3. Bit 3 is written 0 for a plain start and 1 for a repeated start. A command is accepted on a control write that carries enable 1 and command 1 or 2 while the unit is not busy, and the written fields are stored.
- R3: Every bus phase lasts exactly DIV+1 clock cycles, where DIV is divider register bits 7:0. Command-busy stays high for (number of phases)·(DIV+1) cycles.
- R4: A start drives the phases (SCL released, SDA released), (SCL released, SDA low), (SCL low, SDA low). A repeated start first adds the phase (SCL low, SDA released).
- R5: A stop drives the phases (SCL low, SDA low), (SCL released, SDA low), (SCL released, SDA released).
- R6: A data register write, made while enabled and not busy, stores the byte and sends it MSB first. Each bit takes the phase (SCL low, SDA=bit) and then (SCL released, SDA=bit). After the 8 bits come (SCL low, SDA released), (SCL released, SDA released, sda_in sampled at its end) and (SCL low, SDA released).
- R7: If sda_in is high at the acknowledge sample, status bit 0 (no-ack) sets and control bit 3 reads 1. If it is low, control bit 3 reads 0 and no-ack stays unchanged.
- R8: Status bit 7 (command-busy) is high from the accepting edge until the edge on which status bit 3 (session-done) sets. After completion the lines keep their last phase value until the next command.
- R9: While busy, writes to control, data and divider change nothing. A data write made while busy or disabled, or a command written while busy or with enable 0, is ignored and sets status bit 2 (error).
- R10: Status bits 0, 2 and 3 clear when 1 is written to them. A flag that sets in the same cycle as its clear stays set. Bits 1, 4, 5 and 6 read 0, and bit 7 is not writable.
- R11: The interrupt enable register stores bits 0, 1, 3 and 4, and its other bits read 0. irq is high when any status bit is set together with its enable bit.
- R12: A control write with enable 0 while idle releases both lines. A command field of 0 or 3 starts nothing and leaves the lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the register at reg_addr |
| sda_in | input | 1 | Sensed SDA level |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Masked interrupt request |

## Verification
The final phase tick of a command sets session-done, and a software write-1-to-clear of that flag can land on the same clock edge. The bench provokes this by watching its reference model and issuing the status clear exactly in the cycle before the completing edge. It then requires session-done to read 1 afterwards, because the set wins. A second clear issued later, with no completion pending, must leave the flag at 0, which shows that the clear path itself works.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_IE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

  localparam logic [1:0] CMD_START = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;

  localparam logic [REG_W-1:0] IE_KEEP  = 8'h1B;
  localparam logic [REG_W-1:0] W1C_KEEP = 8'h0D;

  typedef enum logic [1:0] {OP_START, OP_RESTART, OP_STOP, OP_BYTE} op_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RS, SQ_S1, SQ_S2, SQ_S3, SQ_P1, SQ_P2, SQ_P3,
    SQ_BLO, SQ_BHI, SQ_ALO, SQ_AHI, SQ_AEND
  } sq_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] STEP = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  op_t               go_op,
  input  logic [BYTE_W-1:0] go_byte,
  input  logic              sda_in,
  input  logic              release_lines,
  output logic              busy,
  output logic              done,
  output logic              byte_done,
  output logic              nack,
  output logic              in_byte,
  output logic              scl_low,
  output logic              sda_low
);
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] BIT_STEP = BIT_W'(1);

  sq_t               st_q, st_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              nack_q, nack_d;
  logic [1:0]        lines_q, lines_d;   // {scl_low, sda_low}

  // line drive of each phase; b is the data bit being sent
  function automatic logic [1:0] drive_of(sq_t s, logic b);
    case (s)
      SQ_RS:   drive_of = 2'b10;
      SQ_S1:   drive_of = 2'b00;
      SQ_S2:   drive_of = 2'b01;
      SQ_S3:   drive_of = 2'b11;
      SQ_P1:   drive_of = 2'b11;
      SQ_P2:   drive_of = 2'b01;
      SQ_P3:   drive_of = 2'b00;
      SQ_BLO:  drive_of = {1'b1, ~b};
      SQ_BHI:  drive_of = {1'b0, ~b};
      SQ_ALO:  drive_of = 2'b10;
      SQ_AHI:  drive_of = 2'b00;
      SQ_AEND: drive_of = 2'b10;
      default: drive_of = 2'b00;
    endcase
  endfunction

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    nack_d  = nack_q;
    if (st_q == SQ_IDLE) begin
      if (go) begin
        case (go_op)
          OP_START:   st_d = SQ_S1;
          OP_RESTART: st_d = SQ_RS;
          OP_STOP:    st_d = SQ_P1;
          default: begin
            st_d    = SQ_BLO;
            shift_d = go_byte;
            bit_d   = '0;
          end
        endcase
      end
    end else if (tick) begin
      case (st_q)
        SQ_RS:  st_d = SQ_S1;
        SQ_S1:  st_d = SQ_S2;
        SQ_S2:  st_d = SQ_S3;
        SQ_P1:  st_d = SQ_P2;
        SQ_P2:  st_d = SQ_P3;
        SQ_BLO: st_d = SQ_BHI;
        SQ_BHI: begin
          if (bit_q == LAST_BIT) begin
            st_d = SQ_ALO;
          end else begin
            st_d    = SQ_BLO;
            bit_d   = bit_q + BIT_STEP;
            shift_d = {shift_q[BYTE_W-2:0], 1'b0};
          end
        end
        SQ_ALO: st_d = SQ_AHI;
        SQ_AHI: begin
          st_d   = SQ_AEND;
          nack_d = sda_in;
        end
        default: st_d = SQ_IDLE;   // S3, P3, AEND finish
      endcase
    end
  end

  always_comb begin
    if (st_d != SQ_IDLE)    lines_d = drive_of(st_d, shift_d[BYTE_W-1]);
    else if (release_lines) lines_d = 2'b00;
    else                    lines_d = lines_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      nack_q  <= 1'b0;
      lines_q <= 2'b00;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      nack_q  <= nack_d;
      lines_q <= lines_d;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign done      = tick && ((st_q == SQ_S3) || (st_q == SQ_P3) || (st_q == SQ_AEND));
  assign byte_done = tick && (st_q == SQ_AEND);
  assign nack      = nack_q;
  assign in_byte   = (st_q == SQ_BLO) || (st_q == SQ_BHI) || (st_q == SQ_ALO) ||
                     (st_q == SQ_AHI) || (st_q == SQ_AEND);
  assign scl_low   = lines_q[1];
  assign sda_low   = lines_q[0];
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              byte_done,
  input  logic              nack,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              go,
  output op_t               go_op,
  output logic [REG_W-1:0]  go_byte,
  output logic              release_lines,
  output logic [DIV_W-1:0]  div,
  output logic              irq,
  output logic              sess_done,
  output logic              err_flag
);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic             en_q, en_d;
  logic [1:0]       cmd_q, cmd_d;
  logic             ackb_q, ackb_d;
  logic [REG_W-1:0] data_q, data_d;
  logic             noack_q, noack_d;
  logic             err_q, err_d;
  logic             sdone_q, sdone_d;
  logic [REG_W-1:0] ie_q, ie_d;
  logic [DIV_W-1:0] div_q, div_d;

  logic             wr_ctrl, wr_data, wr_stat, wr_ie, wr_div;
  logic [1:0]       cmd_w;
  logic             cmd_req, ctrl_take, ctrl_go, data_go, err_set;
  logic [REG_W-1:0] clr, stat_vec;

  always_comb begin
    wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    wr_data   = reg_wr && (reg_addr == A_DATA);
    wr_stat   = reg_wr && (reg_addr == A_STAT);
    wr_ie     = reg_wr && (reg_addr == A_IE);
    wr_div    = reg_wr && (reg_addr == A_DIV);
    cmd_w     = reg_wdata[2:1];
    cmd_req   = (cmd_w == CMD_START) || (cmd_w == CMD_STOP);
    ctrl_take = wr_ctrl && !busy;
    ctrl_go   = ctrl_take && reg_wdata[0] && cmd_req;
    data_go   = wr_data && !busy && en_q;
    err_set   = (wr_ctrl && cmd_req && (busy || !reg_wdata[0])) ||
                (wr_data && (busy || !en_q));
    clr       = wr_stat ? (reg_wdata & W1C_KEEP) : '0;
  end

  always_comb begin
    go = ctrl_go || data_go;
    if (data_go)                go_op = OP_BYTE;
    else if (cmd_w == CMD_STOP) go_op = OP_STOP;
    else if (reg_wdata[3])      go_op = OP_RESTART;
    else                        go_op = OP_START;
  end

  assign go_byte       = reg_wdata;
  assign release_lines = ctrl_take && !reg_wdata[0];

  always_comb begin
    en_d    = ctrl_take ? reg_wdata[0]   : en_q;
    cmd_d   = ctrl_take ? cmd_w          : cmd_q;
    if (byte_done)      ackb_d = nack;
    else if (ctrl_take) ackb_d = reg_wdata[3];
    else                ackb_d = ackb_q;
    data_d  = data_go ? reg_wdata : data_q;
    noack_d = (noack_q && !clr[0]) || (byte_done && nack);
    err_d   = (err_q   && !clr[2]) || err_set;
    sdone_d = (sdone_q && !clr[3]) || done;
    ie_d    = wr_ie ? (reg_wdata & IE_KEEP) : ie_q;
    div_d   = (wr_div && !busy) ? reg_wdata[DIV_W-1:0] : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cmd_q   <= 2'd0;
      ackb_q  <= 1'b0;
      data_q  <= '0;
      noack_q <= 1'b0;
      err_q   <= 1'b0;
      sdone_q <= 1'b0;
      ie_q    <= '0;
      div_q   <= DIV_INIT;
    end else begin
      en_q    <= en_d;
      cmd_q   <= cmd_d;
      ackb_q  <= ackb_d;
      data_q  <= data_d;
      noack_q <= noack_d;
      err_q   <= err_d;
      sdone_q <= sdone_d;
      ie_q    <= ie_d;
      div_q   <= div_d;
    end
  end

  assign stat_vec = {busy, 3'b000, sdone_q, err_q, 1'b0, noack_q};

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0000, ackb_q, cmd_q, en_q};
      A_DATA:  reg_rdata = data_q;
      A_STAT:  reg_rdata = stat_vec;
      A_IE:    reg_rdata = ie_q;
      A_DIV:   reg_rdata = REG_W'(div_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = |(stat_vec & ie_q);
  assign div       = div_q;
  assign sess_done = sdone_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/i2cm_cmd_unit.sv
module i2cm_cmd_unit
  import i2cm_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              sda_in,
  output logic              scl_low,
  output logic              sda_low,
  output logic              irq
);
  logic             busy_w, done_w, byte_done_w, nack_w, in_byte_w, tick_w;
  logic             go_w, release_w, sess_done_w, err_flag_w;
  op_t              go_op_w;
  logic [REG_W-1:0] go_byte_w;
  logic [DIV_W-1:0] div_w;

  i2cm_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy_w), .done(done_w),
    .byte_done(byte_done_w), .nack(nack_w), .reg_rdata(reg_rdata),
    .go(go_w), .go_op(go_op_w), .go_byte(go_byte_w),
    .release_lines(release_w), .div(div_w), .irq(irq),
    .sess_done(sess_done_w), .err_flag(err_flag_w)
  );

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .div(div_w), .tick(tick_w)
  );

  i2cm_seq #(.BYTE_W(REG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .go(go_w), .go_op(go_op_w),
    .go_byte(go_byte_w), .sda_in(sda_in), .release_lines(release_w),
    .busy(busy_w), .done(done_w), .byte_done(byte_done_w), .nack(nack_w),
    .in_byte(in_byte_w), .scl_low(scl_low), .sda_low(sda_low)
  );
endmodule

// File: rtl/i2cm_cmd_unit_chk.sv
module i2cm_cmd_unit_chk
  import i2cm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              scl_low,
  input logic              sda_low,
  input logic              busy,
  input logic              tick,
  input logic              in_byte,
  input logic              sess_done,
  input logic              err_flag
);
  // lines stay put while idle and untouched by software
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(reg_wr)) |-> ($stable(scl_low) && $stable(sda_low)));

  // busy ends exactly when session-done is set
  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sess_done);

  // data bit stable while clock released inside a byte
  assert_sda_stable_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !scl_low && $past(!scl_low)) |-> $stable(sda_low));

  // a data write arriving during a command is flagged
  assert_busy_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_addr == A_DATA)) |=> err_flag);

  // divider ticks only while a command runs
  assert_tick_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);
endmodule

bind i2cm_cmd_unit i2cm_cmd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .scl_low(scl_low), .sda_low(sda_low), .busy(busy_w), .tick(tick_w),
  .in_byte(in_byte_w), .sess_done(sess_done_w), .err_flag(err_flag_w)
);

// File: tb/i2cm_cmd_unit_tb.sv
`timescale 1ns/1ps
module i2cm_cmd_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_low, sda_low, irq, sda_in;
  logic       slave_hold = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign sda_in = ~(sda_low | slave_hold);

  i2cm_cmd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
    .scl_low(scl_low), .sda_low(sda_low), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit        m_busy, m_en, m_b3, m_noack, m_err, m_done, m_scl, m_sda;
  bit        m_nack, m_isbyte;
  bit [1:0]  m_cmd;
  bit [7:0]  m_data, m_ie, m_div;
  int        m_cnt;
  bit [2:0]  m_ph[$];   // {scl_low, sda_low, sample}

  function automatic bit [7:0] m_read(bit [2:0] a);
    case (a)
      3'd0: return {4'b0, m_b3, m_cmd, m_en};
      3'd1: return m_data;
      3'd2: return {m_busy, 3'b000, m_done, m_err, 1'b0, m_noack};
      3'd3: return m_ie;
      3'd4: return m_div;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit ob, tk, acc, dset, nset, eset, req;
    bit [7:0] clr, w;
    bit [2:0] e;
    if (!rst_n) begin
      m_busy = 0; m_en = 0; m_b3 = 0; m_noack = 0; m_err = 0; m_done = 0;
      m_scl = 0; m_sda = 0; m_nack = 0; m_isbyte = 0; m_cmd = 0;
      m_data = 0; m_ie = 0; m_div = 8'd4; m_cnt = 0; m_ph.delete();
    end else begin
      ob = m_busy; tk = m_busy && (m_cnt == int'(m_div));
      acc = 0; dset = 0; nset = 0; eset = 0; clr = 0; w = reg_wdata;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            req = (w[2:1] == 2'd1) || (w[2:1] == 2'd2);
            if (ob) begin
              if (req) eset = 1;
            end else begin
              m_en = w[0]; m_cmd = w[2:1]; m_b3 = w[3];
              if (req && w[0]) begin
                acc = 1; m_isbyte = 0; m_ph.delete();
                if (w[2:1] == 2'd2) begin
                  m_ph.push_back(3'b110); m_ph.push_back(3'b010); m_ph.push_back(3'b000);
                end else begin
                  if (w[3]) m_ph.push_back(3'b100);
                  m_ph.push_back(3'b000); m_ph.push_back(3'b010); m_ph.push_back(3'b110);
                end
              end else if (req) eset = 1;
              if (!w[0]) begin m_scl = 0; m_sda = 0; end
            end
          end
          3'd1: begin
            if (ob || !m_en) eset = 1;
            else begin
              acc = 1; m_isbyte = 1; m_data = w; m_ph.delete();
              for (int i = 7; i >= 0; i--) begin
                m_ph.push_back({1'b1, ~w[i], 1'b0});
                m_ph.push_back({1'b0, ~w[i], 1'b0});
              end
              m_ph.push_back(3'b100); m_ph.push_back(3'b001); m_ph.push_back(3'b100);
            end
          end
          3'd2: clr = w & 8'h0D;
          3'd3: m_ie = w & 8'h1B;
          3'd4: if (!ob) m_div = w;
          default: ;
        endcase
      end
      if (ob) begin
        if (tk) begin
          e = m_ph.pop_front();
          if (e[0]) m_nack = !(m_sda || slave_hold);
          if (m_ph.size() == 0) begin
            m_busy = 0; dset = 1;
            if (m_isbyte) begin nset = m_nack; m_b3 = m_nack; end
          end else begin
            m_scl = m_ph[0][2]; m_sda = m_ph[0][1];
          end
          m_cnt = 0;
        end else m_cnt++;
      end
      if (acc) begin
        m_busy = 1; m_cnt = 0; m_scl = m_ph[0][2]; m_sda = m_ph[0][1];
      end
      m_noack = (m_noack && !clr[0]) || nset;
      m_err   = (m_err   && !clr[2]) || eset;
      m_done  = (m_done  && !clr[3]) || dset;
    end
  end

  // ---------------- checking ----------------
  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (running && rst_n) begin
      check("R3 scl_low", scl_low, m_scl);
      check("R3 sda_low", sda_low, m_sda);
      check("R11 irq", irq, |({m_busy, 3'b000, m_done, m_err, 1'b0, m_noack} & m_ie));
      check("R10 rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr_now(bit [2:0] a, bit [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd2;
  endtask

  task automatic wr(bit [2:0] a, bit [7:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(bit [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 3'd2;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  // issue a command and count the cycles busy reads high
  task automatic timed(bit [2:0] a, bit [7:0] d, int exp, string tag);
    int n = 0;
    wr(a, d);
    #1;
    while (reg_rdata[7]) begin n++; @(negedge clk); #1; end
    check(tag, n, exp);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    running = 1'b1;
    #1;
    // R1 reset state
    check("R1 scl", scl_low, 1'b0);
    check("R1 sda", sda_low, 1'b0);
    check("R1 irq", irq, 1'b0);
    rd(3'd2, v); check("R1 status", v, 8'h00);
    rd(3'd0, v); check("R1 ctrl", v, 8'h00);
    rd(3'd4, v); check("R1 div", v, 8'h04);

    // R3 divider, R11 enable mask
    wr(3'd4, 8'd2); rd(3'd4, v); check("R3 div", v, 8'd2);
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R11 ie mask", v, 8'h1B);
    wr(3'd3, 8'h08);

    // R2 R4 start: 3 phases * 3 cycles
    timed(3'd0, 8'h03, 9, "R3 start length");
    rd(3'd2, v); check("R2 start done", v, 8'h08);
    check("R11 irq done", irq, 1'b1);
    check("R4 start end lines", {scl_low, sda_low}, 2'b11);
    wr(3'd2, 8'h08); rd(3'd2, v); check("R10 clear", v, 8'h00);
    wr(3'd0, 8'h01);

    // R6 byte with ack, R9 ignored writes while busy
    slave_hold = 1'b1;
    wr(3'd1, 8'hA5);
    repeat (3) @(negedge clk);
    #1 check("R8 busy bit", reg_rdata, 8'h80);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h05);
    wait_idle();
    rd(3'd2, v); check("R9 err and done", v, 8'h0C);
    rd(3'd4, v); check("R9 div kept", v, 8'd2);
    rd(3'd0, v); check("R7 ack bit3", v, 8'h01);
    rd(3'd1, v); check("R6 data kept", v, 8'hA5);
    check("R6 end lines", {scl_low, sda_low}, 2'b10);
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R10 bit7 not writable", v, 8'h00);

    // R7 byte with no-ack: 19 phases * 3 cycles
    slave_hold = 1'b0;
    wr(3'd3, 8'h09);
    timed(3'd1, 8'h3C, 57, "R3 byte length");
    rd(3'd2, v); check("R7 noack status", v, 8'h09);
    rd(3'd0, v); check("R7 nack bit3", v, 8'h09);
    check("R11 irq noack", irq, 1'b1);
    wr(3'd2, 8'h09);

    // R4 repeated start: 4 phases
    timed(3'd0, 8'h0B, 12, "R4 restart length");
    check("R4 restart lines", {scl_low, sda_low}, 2'b11);
    wr(3'd2, 8'h08);
    wr(3'd0, 8'h01);

    // R5 stop with clear landing on the completing edge
    wr(3'd0, 8'h05);
    while (!(m_busy && m_ph.size() == 1 && m_cnt == int'(m_div))) @(negedge clk);
    wr_now(3'd2, 8'h08);
    wait_idle();
    rd(3'd2, v); check("R10 set wins", v, 8'h08);
    check("R5 stop lines", {scl_low, sda_low}, 2'b00);
    wr(3'd2, 8'h08); rd(3'd2, v); check("R10 later clear", v, 8'h00);

    // R12 command 3 does nothing
    wr(3'd0, 8'h07);
    repeat (4) @(negedge clk);
    #1 check("R12 cmd3 idle", reg_rdata, 8'h00);
    check("R12 cmd3 lines", {scl_low, sda_low}, 2'b00);

    // R12 disable releases lines
    wr(3'd0, 8'h03); wait_idle();
    check("R12 held low", {scl_low, sda_low}, 2'b11);
    wr(3'd0, 8'h00); #1;
    check("R12 released", {scl_low, sda_low}, 2'b00);

    // R9 writes while disabled
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'h55);
    rd(3'd2, v); check("R9 disabled data err", v, 8'h04);
    rd(3'd1, v); check("R9 data unchanged", v, 8'h3C);
    wr(3'd2, 8'h04);
    wr(3'd0, 8'h02);
    rd(3'd2, v); check("R9 disabled cmd err", v, 8'h04);

    // R3 divider zero: one cycle per phase
    wr(3'd2, 8'hFF);
    wr(3'd4, 8'd0);
    timed(3'd0, 8'h03, 3, "R3 div0 start");
    timed(3'd0, 8'h05, 3, "R5 div0 stop");
    check("R5 div0 lines", {scl_low, sda_low}, 2'b00);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule